// File: doc/BRIEF.md
# Three-Tier Interrupt Arbiter with Selectable Modes

The block gathers 48 interrupt requests and turns them into a single service interrupt. Sixteen of them come from external pins, sixteen from internal system-error flags and sixteen from internal latched clock-error flags. Each external pin has its own sense setting, which can be a level of either polarity or an edge of either direction. The internal flags always act as active-high levels. Every source has its own enable bit. An enabled source that fires sets a sticky pending bit.

An arbiter runs in one of four modes, chosen at runtime. In the legacy mode it only reacts to the OR of the raw system-error flags. In the flat mode it runs one round-robin over all 48 pending bits. The two tiered modes give fixed priority across the groups and round-robin inside each group, either with or without pre-emption. The winner's 6-bit vector is placed in an in-service register together with a valid flag. The interrupt output stays asserted until software writes the acknowledge strobe. A second, PCI-style interrupt output follows the first one when it is enabled.

Software programs the block through a small write port. Address 0 holds the 32-bit external sense word, with two bits per pin. Addresses 1, 2 and 3 hold the 16-bit enable words for the external, system-error and clock-error groups. Address 4 holds the control bits. A write of any data to address 5 is the acknowledge.

Top module: `irq_arbiter48`

## Requirements
- R1: The external pin sense is set by the two-bit field wr_data[2i+1:2i] at address 0: 00 is active-high level, 01 is active-low level, 10 is rising edge and 11 is falling edge. An edge sets the pending bit once, one clock after the pin changes.
- R2: System-error and clock-error inputs are sensed as active-high levels. A low input never sets a pending bit.
- R3: Bit i of the enable word at address 1, 2 or 3 gates the external, system-error or clock-error source i. A source whose enable bit is 0 never becomes pending. pend_o shows the pending bit at the same index as the source's vector: external sources are 0 to 15, system-error sources are 16 to 31 and clock-error sources are 32 to 47.
- R4: Mode 00 (bits [1:0] at address 4) is the legacy mode. sys_irq_o rises one clock after any raw system-error bit is high while the trigger is armed, and the enables are not applied. No vector is granted in this mode. The acknowledge drops sys_irq_o. The trigger re-arms only after a clock in which all 16 bits are low.
- R5: Mode 01 is flat round-robin over all 48 pending bits. The search starts one index after the last winner and wraps from 47 to 0. A grant loads isr_vec_o, sets isr_valid_o and clears the winner's pending bit.
- R6: While isr_valid_o is set, no new grant is made. The acknowledge clears isr_valid_o and sys_irq_o at the next clock edge. The earliest next grant is on the following edge.
- R7: In tiered modes (10 and 11), clock-error sources have priority over system-error sources, which have priority over external sources. Inside each group the arbitration is round-robin, starting after that group's last winner.
- R8: In mode 10, the vector in service is held unchanged until it is acknowledged, even if a higher-tier request is pending.
- R9: In mode 11, a pending request from a strictly higher tier replaces the vector in service. The displaced source's pending bit is set again. Requests from the same tier or a lower tier do not pre-empt.
- R10: pci_irq_o equals sys_irq_o when bit 2 at address 4 is 1, and is 0 otherwise.
- R11: After reset, all outputs are 0. All sense fields are active-high level, all enables are 0, the mode is 00 and the PCI enable is 0.
- R12: If an acknowledge and a pre-emption fall on the same edge, the acknowledge wins. The in-service entry is cleared, the displaced source is not made pending again, and the higher-tier request is granted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 16 | External interrupt pins |
| sys_err_i | input | 16 | Internal system-error flags |
| clk_err_i | input | 16 | Internal latched clock-error flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| sys_irq_o | output | 1 | System-error interrupt output |
| pci_irq_o | output | 1 | PCI-style interrupt output |
| isr_valid_o | output | 1 | In-service entry valid |
| isr_vec_o | output | 6 | In-service source vector |
| pend_o | output | 48 | Pending bits, indexed by vector |

## Verification
The acknowledge strobe and a pre-emption can land on the same clock edge. To provoke this, a clock-error request is pulsed so that it becomes pending exactly one edge before the acknowledge write while an external vector is in service. The result is judged on the edge after: the valid flag must be clear, the clock-error bit must still be pending, and the displaced external bit must not be pending again. On the next edge the clock-error vector must be granted.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int GRP_SRC   = 16;
  localparam int GRP_NUM   = 3;
  localparam int SRC_NUM   = GRP_SRC * GRP_NUM;
  localparam int VEC_W     = $clog2(SRC_NUM);
  localparam int GRP_IDX_W = $clog2(GRP_SRC);
  localparam int GRP_W     = $clog2(GRP_NUM);
  localparam int CFG_W     = 2 * GRP_SRC;
  localparam int ADDR_W    = 3;

  typedef enum logic [1:0] {
    ARB_OFF      = 2'd0,
    ARB_FLAT     = 2'd1,
    ARB_TIER     = 2'd2,
    ARB_TIER_PRE = 2'd3
  } arb_mode_e;

  localparam logic [ADDR_W-1:0] REG_SENSE  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_EN_EXT = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EN_SYS = 3'd2;
  localparam logic [ADDR_W-1:0] REG_EN_CLK = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_ACK    = 3'd5;
endpackage

// File: rtl/irq_sense_cond.sv
module irq_sense_cond #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] sense_i,
  output logic [N-1:0]   hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      always_comb begin
        case (sense_i[2*i +: 2])
          2'b00:   hit_o[i] = pin_i[i];
          2'b01:   hit_o[i] = ~pin_i[i];
          2'b10:   hit_o[i] = pin_i[i] & ~prev_q[i];
          default: hit_o[i] = ~pin_i[i] & prev_q[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the candidate closest to ptr_i is assigned last.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int p;
      p = (int'(ptr_i) + k) % N;
      if (req_i[p]) begin
        found_o = 1'b1;
        idx_o   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/irq_legacy_trig.sv
module irq_legacy_trig #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_i,
  input  logic         ack_i,
  output logic         irq_o
);
  logic armed_q, armed_d, irq_q, irq_d;
  logic any_err, fire;

  assign any_err = |err_i;
  assign fire    = armed_q & any_err;

  always_comb begin
    armed_d = armed_q;
    irq_d   = irq_q;
    if (fire) begin
      irq_d   = 1'b1;
      armed_d = 1'b0;
    end else begin
      if (ack_i)    irq_d   = 1'b0;
      if (!any_err) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_arbiter48.sv
module irq_arbiter48
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GRP_SRC-1:0] ext_irq_i,
  input  logic [GRP_SRC-1:0] sys_err_i,
  input  logic [GRP_SRC-1:0] clk_err_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  output logic               sys_irq_o,
  output logic               pci_irq_o,
  output logic               isr_valid_o,
  output logic [VEC_W-1:0]   isr_vec_o,
  output logic [SRC_NUM-1:0] pend_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Configuration registers
  logic [CFG_W-1:0]   sense_q;
  logic [SRC_NUM-1:0] en_q;
  arb_mode_e          mode_q;
  logic               pci_en_q;
  logic               we_sense, we_ext, we_sys, we_clk, we_ctrl, ack;

  assign we_sense = wr_en_i && (wr_addr_i == REG_SENSE);
  assign we_ext   = wr_en_i && (wr_addr_i == REG_EN_EXT);
  assign we_sys   = wr_en_i && (wr_addr_i == REG_EN_SYS);
  assign we_clk   = wr_en_i && (wr_addr_i == REG_EN_CLK);
  assign we_ctrl  = wr_en_i && (wr_addr_i == REG_CTRL);
  assign ack      = wr_en_i && (wr_addr_i == REG_ACK);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      sense_q  <= '0;
      en_q     <= '0;
      mode_q   <= ARB_OFF;
      pci_en_q <= 1'b0;
    end else begin
      if (we_sense) sense_q <= wr_data_i;
      if (we_ext)   en_q[0*GRP_SRC +: GRP_SRC] <= wr_data_i[GRP_SRC-1:0];
      if (we_sys)   en_q[1*GRP_SRC +: GRP_SRC] <= wr_data_i[GRP_SRC-1:0];
      if (we_clk)   en_q[2*GRP_SRC +: GRP_SRC] <= wr_data_i[GRP_SRC-1:0];
      if (we_ctrl) begin
        mode_q   <= arb_mode_e'(wr_data_i[1:0]);
        pci_en_q <= wr_data_i[2];
      end
    end
  end

  // Source conditioning
  logic [GRP_SRC-1:0] ext_hit;
  logic [SRC_NUM-1:0] det;

  irq_sense_cond #(.N(GRP_SRC)) u_sense (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .pin_i  (ext_irq_i),
    .sense_i(sense_q),
    .hit_o  (ext_hit)
  );

  assign det = {clk_err_i, sys_err_i, ext_hit} & en_q;

  // Legacy OR trigger
  logic legacy_irq;
  irq_legacy_trig #(.N(GRP_SRC)) u_legacy (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .err_i(sys_err_i),
    .ack_i(ack),
    .irq_o(legacy_irq)
  );

  // Arbitration state
  logic [SRC_NUM-1:0]                pend_q, pend_d;
  logic                              isv_q, isv_d;
  logic [VEC_W-1:0]                  vec_q, vec_d;
  logic [VEC_W-1:0]                  flat_ptr_q, flat_ptr_d;
  logic [GRP_NUM-1:0][GRP_IDX_W-1:0] tier_ptr_q, tier_ptr_d;

  // Pickers: one flat, one per tier
  logic                              flat_found;
  logic [VEC_W-1:0]                  flat_idx;
  logic [GRP_NUM-1:0]                t_found;
  logic [GRP_NUM-1:0][GRP_IDX_W-1:0] t_idx;

  irq_rr_pick #(.N(SRC_NUM), .IW(VEC_W)) u_flat (
    .req_i  (pend_q),
    .ptr_i  (flat_ptr_q),
    .found_o(flat_found),
    .idx_o  (flat_idx)
  );

  genvar g;
  generate
    for (g = 0; g < GRP_NUM; g++) begin : g_tier
      irq_rr_pick #(.N(GRP_SRC), .IW(GRP_IDX_W)) u_pick (
        .req_i  (pend_q[g*GRP_SRC +: GRP_SRC]),
        .ptr_i  (tier_ptr_q[g]),
        .found_o(t_found[g]),
        .idx_o  (t_idx[g])
      );
    end
  endgenerate

  logic                 tier_found;
  logic [GRP_W-1:0]     tier_grp, cur_grp;
  logic [GRP_IDX_W-1:0] tier_idx;
  logic [VEC_W-1:0]     tier_vec;

  always_comb begin
    tier_found = 1'b0;
    tier_grp   = '0;
    tier_idx   = '0;
    for (int t = 0; t < GRP_NUM; t++) begin
      if (t_found[t]) begin
        tier_found = 1'b1;
        tier_grp   = GRP_W'(t);
        tier_idx   = t_idx[t];
      end
    end
  end

  assign tier_vec = VEC_W'(int'(tier_grp) * GRP_SRC + int'(tier_idx));
  assign cur_grp  = GRP_W'(int'(vec_q) / GRP_SRC);

  logic             grant;
  logic [VEC_W-1:0] gvec;
  logic             tiered;

  assign tiered = (mode_q == ARB_TIER) || (mode_q == ARB_TIER_PRE);

  always_comb begin
    pend_d     = pend_q | det;
    isv_d      = isv_q;
    vec_d      = vec_q;
    flat_ptr_d = flat_ptr_q;
    tier_ptr_d = tier_ptr_q;
    grant      = 1'b0;
    gvec       = '0;
    if (ack) begin
      isv_d = 1'b0;
    end else if (!isv_q) begin
      if (mode_q == ARB_FLAT && flat_found) begin
        grant = 1'b1;
        gvec  = flat_idx;
      end else if (tiered && tier_found) begin
        grant = 1'b1;
        gvec  = tier_vec;
      end
    end else if (mode_q == ARB_TIER_PRE && tier_found && tier_grp > cur_grp) begin
      grant         = 1'b1;
      gvec          = tier_vec;
      pend_d[vec_q] = 1'b1;
    end
    if (grant) begin
      isv_d        = 1'b1;
      vec_d        = gvec;
      pend_d[gvec] = 1'b0;
      if (mode_q == ARB_FLAT)
        flat_ptr_d = (gvec == VEC_W'(SRC_NUM - 1)) ? '0 : gvec + 1'b1;
      else
        tier_ptr_d[tier_grp] = (tier_idx == GRP_IDX_W'(GRP_SRC - 1)) ? '0 : tier_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pend_q     <= '0;
      isv_q      <= 1'b0;
      vec_q      <= '0;
      flat_ptr_q <= '0;
      tier_ptr_q <= '0;
    end else begin
      pend_q     <= pend_d;
      isv_q      <= isv_d;
      vec_q      <= vec_d;
      flat_ptr_q <= flat_ptr_d;
      tier_ptr_q <= tier_ptr_d;
    end
  end

  assign sys_irq_o   = (mode_q == ARB_OFF) ? legacy_irq : isv_q;
  assign pci_irq_o   = sys_irq_o & pci_en_q;
  assign isr_valid_o = isv_q;
  assign isr_vec_o   = vec_q;
  assign pend_o      = pend_q;
endmodule

// File: rtl/irq_arbiter48_chk.sv
module irq_arbiter48_chk
  import irq_arb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ack,
  input logic [1:0]         mode,
  input logic               isr_valid,
  input logic [VEC_W-1:0]   isr_vec,
  input logic               sys_irq,
  input logic               pci_irq
);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !isr_valid);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_valid && !ack) |=> isr_valid);

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isr_valid |-> (int'(isr_vec) < SRC_NUM));

  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && isr_valid && !ack) |=> $stable(isr_vec));

  assert_preempt_upward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_valid && $past(isr_valid) && isr_vec != $past(isr_vec))
      |-> (int'(isr_vec) / GRP_SRC > int'($past(isr_vec)) / GRP_SRC));

  assert_off_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !isr_valid) |=> !isr_valid);

  assert_pci_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_irq |-> sys_irq);
endmodule

bind irq_arbiter48 irq_arbiter48_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_q),
  .ack      (ack),
  .mode     (mode_q),
  .isr_valid(isr_valid_o),
  .isr_vec  (isr_vec_o),
  .sys_irq  (sys_irq_o),
  .pci_irq  (pci_irq_o)
);

// File: tb/test_irq_arbiter48.sv
module test_irq_arbiter48;
  import irq_arb_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [GRP_SRC-1:0] ext_irq = '0, sys_err = '0, clk_err = '0;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [CFG_W-1:0]   wr_data = '0;
  logic               sys_irq, pci_irq, isr_valid;
  logic [VEC_W-1:0]   isr_vec;
  logic [SRC_NUM-1:0] pend;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_arbiter48 i_irq_arbiter48 (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .sys_err_i(sys_err),
    .clk_err_i(clk_err), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sys_irq_o(sys_irq), .pci_irq_o(pci_irq), .isr_valid_o(isr_valid),
    .isr_vec_o(isr_vec), .pend_o(pend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CFG_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_ack();
    wr(REG_ACK, '0);
  endtask

  task automatic pulse(input logic [15:0] e, input logic [15:0] s, input logic [15:0] c);
    ext_irq = e; sys_err = s; clk_err = c;
    tick();
    ext_irq = '0; sys_err = '0; clk_err = '0;
  endtask

  task automatic do_reset();
    ext_irq = '0; sys_err = '0; clk_err = '0; wr_en = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic setup_arb(input logic [1:0] mode);
    do_reset();
    wr(REG_SENSE, 32'hAAAA_AAAA);
    wr(REG_EN_EXT, 32'hFFFF);
    wr(REG_EN_SYS, 32'hFFFF);
    wr(REG_EN_CLK, 32'hFFFF);
    wr(REG_CTRL, {30'd0, mode});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 sys_irq", 64'(sys_irq), 0);
    chk("R11 pci_irq", 64'(pci_irq), 0);
    chk("R11 isr_valid", 64'(isr_valid), 0);
    chk("R11 isr_vec", 64'(isr_vec), 0);
    chk("R11 pend", 64'(pend), 0);
  endtask

  task automatic t_sense();
    do_reset();
    wr(REG_SENSE, 32'h0000_00E4);
    wr(REG_EN_EXT, 32'h000F);
    tick();
    chk("R1 active-low pending", 64'(pend[3:0]), 64'h2);
    ext_irq = 16'h000F;
    tick();
    chk("R1 high level and rising", 64'(pend[3:0]), 64'h7);
    ext_irq = 16'h0000;
    tick();
    chk("R1 falling edge", 64'(pend[3:0]), 64'hF);
  endtask

  task automatic t_mask();
    do_reset();
    wr(REG_EN_SYS, 32'h0060);
    wr(REG_EN_CLK, 32'h0080);
    sys_err = 16'h0020; clk_err = 16'h0180; ext_irq = 16'hFFFF;
    tick(2);
    chk("R2 R3 pending pattern", 64'(pend), (64'd1 << 21) | (64'd1 << 39));
    sys_err = '0; clk_err = '0; ext_irq = '0;
  endtask

  task automatic t_legacy();
    do_reset();
    wr(REG_EN_EXT, 32'hFFFF);
    wr(REG_EN_CLK, 32'hFFFF);
    ext_irq = 16'hFFFF; clk_err = 16'hFFFF;
    tick(2);
    chk("R4 other groups ignored", 64'(sys_irq), 0);
    ext_irq = '0; clk_err = '0;
    sys_err = 16'h0010;
    tick();
    chk("R4 fires on OR", 64'(sys_irq), 1);
    chk("R4 no vector granted", 64'(isr_valid), 0);
    do_ack();
    tick(2);
    chk("R4 not rearmed while bit high", 64'(sys_irq), 0);
    sys_err = '0;
    tick();
    sys_err = 16'h0200;
    tick();
    chk("R4 rearmed after all clear", 64'(sys_irq), 1);
    wr(REG_CTRL, 32'h4);
    chk("R10 pci follows in legacy", 64'(pci_irq), 1);
    sys_err = '0;
  endtask

  task automatic t_flat();
    setup_arb(2'd1);
    pulse(16'h0408, 16'h0004, 16'h0);
    tick();
    chk("R5 first winner", 64'(isr_vec), 3);
    chk("R5 valid", 64'(isr_valid), 1);
    chk("R5 winner pending cleared", 64'(pend[3]), 0);
    tick();
    chk("R6 held before ack", 64'(isr_vec), 3);
    do_ack();
    chk("R6 ack clears valid", 64'(isr_valid), 0);
    chk("R6 ack clears irq", 64'(sys_irq), 0);
    tick();
    chk("R5 second winner", 64'(isr_vec), 10);
    do_ack(); tick();
    chk("R5 third winner", 64'(isr_vec), 18);
    do_ack();
    pulse(16'h0002, 16'h0200, 16'h0);
    tick();
    chk("R5 round-robin after 18", 64'(isr_vec), 25);
    do_ack(); tick();
    chk("R5 wrap to low index", 64'(isr_vec), 1);
    do_ack();
  endtask

  task automatic t_tier();
    setup_arb(2'd2);
    pulse(16'h0020, 16'h0002, 16'h0001);
    tick();
    chk("R7 clock tier first", 64'(isr_vec), 32);
    do_ack(); tick();
    chk("R7 system tier second", 64'(isr_vec), 17);
    do_ack(); tick();
    chk("R7 external tier last", 64'(isr_vec), 5);
    do_ack();
    pulse(16'h0, 16'h0009, 16'h0);
    tick();
    chk("R7 in-tier round-robin", 64'(isr_vec), 19);
    do_ack(); tick();
    chk("R7 in-tier next", 64'(isr_vec), 16);
    do_ack();
  endtask

  task automatic t_nopreempt();
    setup_arb(2'd2);
    pulse(16'h0010, 16'h0, 16'h0);
    tick();
    chk("R8 external granted", 64'(isr_vec), 4);
    pulse(16'h0, 16'h0, 16'h0004);
    tick(2);
    chk("R8 held against higher tier", 64'(isr_vec), 4);
    chk("R8 higher tier pending", 64'(pend[34]), 1);
    do_ack(); tick();
    chk("R8 granted after ack", 64'(isr_vec), 34);
    do_ack();
  endtask

  task automatic t_preempt();
    setup_arb(2'd3);
    pulse(16'h0010, 16'h0, 16'h0);
    tick();
    chk("R9 external granted", 64'(isr_vec), 4);
    pulse(16'h0, 16'h0040, 16'h0);
    tick();
    chk("R9 pre-empted vector", 64'(isr_vec), 22);
    chk("R9 displaced pending again", 64'(pend[4]), 1);
    chk("R9 winner pending cleared", 64'(pend[22]), 0);
    pulse(16'h0080, 16'h0, 16'h0);
    tick();
    chk("R9 lower tier no pre-empt", 64'(isr_vec), 22);
    pulse(16'h0, 16'h0100, 16'h0);
    tick();
    chk("R9 same tier no pre-empt", 64'(isr_vec), 22);
    do_ack(); tick();
    chk("R9 same tier after ack", 64'(isr_vec), 24);
    do_ack();
  endtask

  task automatic t_collide();
    setup_arb(2'd3);
    pulse(16'h0010, 16'h0, 16'h0);
    tick();
    chk("R12 setup vector", 64'(isr_vec), 4);
    clk_err = 16'h0002;
    tick();
    clk_err = '0;
    do_ack();
    chk("R12 ack wins valid", 64'(isr_valid), 0);
    chk("R12 request still pending", 64'(pend[33]), 1);
    chk("R12 displaced not restored", 64'(pend[4]), 0);
    tick();
    chk("R12 granted next edge", 64'(isr_vec), 33);
    chk("R12 valid next edge", 64'(isr_valid), 1);
  endtask

  task automatic t_pci();
    setup_arb(2'd1);
    pulse(16'h0001, 16'h0, 16'h0);
    tick();
    chk("R10 sys_irq set", 64'(sys_irq), 1);
    chk("R10 pci off when disabled", 64'(pci_irq), 0);
    do_ack();
    wr(REG_CTRL, 32'h5);
    pulse(16'h0002, 16'h0, 16'h0);
    tick();
    chk("R10 pci on when enabled", 64'(pci_irq), 1);
    do_ack();
    chk("R10 pci drops with ack", 64'(pci_irq), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_sense();
    t_mask();
    t_legacy();
    t_flat();
    t_tier();
    t_nopreempt();
    t_preempt();
    t_collide();
    t_pci();
    summary();
  end
endmodule